// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the 32-bit memory-mapped register front end of an interrupt controller that delivers interrupts as message-signalled writes. A host issues one access per cycle over a simple request/response interface. The block decodes the word offset, returns read data one cycle later, and converts writes into single-cycle set and clear strobes for the per-source pending and enable bits. Those bits, the per-source trigger configuration and the rectified input levels are held in a separate gateway block, which feeds them back to this block for reads.

The block itself stores the global interrupt-enable flag and one target word per source. It also stores a last generated message word, and a write to that register emits a one-cycle message request. Sources are numbered 1 to `NSRC`, and source 0 does not exist. The gateway reads target words through a dedicated read port, so bus traffic does not block it.

Top module: `irq_reg_front`

## Requirements
- R1: An access whose offset has either of its two low bits set returns `resp_err`=1 and read data 0, and produces no strobe, no configuration write, no message and no change of any stored value.
- R2: A read at offset 0x0000 returns 0x8000_0004 ORed with the stored enable flag at bit 8. A write there stores only bit 8, and that bit drives `dom_ie`. Reset clears it.
- R3: Offset 0x0004+4k (k < NSRC) addresses source k+1's trigger configuration. A read returns that source's 3-bit field from `gw_cfg`, zero-extended. A write pulses `cfg_we` with `cfg_src`=k+1 and `cfg_val` equal to write bits [2:0], or 0 if write bit 10 is set.
- R4: A read of word w at 0x1C00+4w returns the pending bits of sources 32w..32w+31, with source n at bit n mod 32. The same read at 0x1D00+4w returns the rectified input bits, and at 0x1E00+4w it returns the enable bits. Source 0 always reads 0.
- R5: Reads of the clear-enable array (0x1F00+4w) and of every by-number register (0x1CDC, 0x1DDC, 0x1EDC, 0x1FDC, 0x2000, 0x2004) return 0.
- R6: A write to word w of the set-pending (0x1C00), clear-pending (0x1D00), set-enable (0x1E00) or clear-enable (0x1F00) array raises the matching strobe for each source whose data bit is 1. Zero bits and source 0 raise nothing.
- R7: A write of value v to set-pending (0x1CDC or 0x2000), clear-pending (0x1DDC), set-enable (0x1EDC) or clear-enable (0x1FDC) by number raises the strobe bit v alone when 1 ≤ v ≤ NSRC, and no strobe otherwise.
- R8: A write to 0x2004 reverses the byte order of the value and then acts as a set-pending-by-number write.
- R9: Offset 0x3004+4k holds source k+1's target word. Writes keep everything except bit 11. The stored word reads back on the bus and, one cycle after `tgt_rd_src` selects the source, on `tgt_rd_word`.
- R10: A write to 0x3000 stores the value with bits [17:12] cleared, which reads back there. It also pulses `msi_valid` with `msi_hart` = bits [31:18] and `msi_eiid` = bits [10:0].
- R11: `resp_valid` is high exactly in the cycle after each cycle with `req_valid`. Read data, `resp_err` and all strobes and pulses appear in that same cycle.
- R12: A word-aligned offset matching no register reads 0 without error and a write there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response for previous cycle's request |
| resp_err | output | 1 | Request rejected (misaligned) |
| resp_rdata | output | 32 | Read data |
| gw_pend | input | NSRC+1 | Pending bits from gateway, index = source |
| gw_en | input | NSRC+1 | Enable bits from gateway |
| gw_rect | input | NSRC+1 | Rectified input bits from gateway |
| gw_cfg | input | 3*(NSRC+1) | Trigger mode per source, source n at [3n+2:3n] |
| set_ip | output | NSRC+1 | Set-pending strobes |
| clr_ip | output | NSRC+1 | Clear-pending strobes |
| set_ie | output | NSRC+1 | Set-enable strobes |
| clr_ie | output | NSRC+1 | Clear-enable strobes |
| cfg_we | output | 1 | Trigger configuration write pulse |
| cfg_src | output | IDX_W | Source of the configuration write |
| cfg_val | output | 3 | Trigger mode to store |
| dom_ie | output | 1 | Global interrupt enable |
| tgt_rd_src | input | IDX_W | Source whose target the gateway reads |
| tgt_rd_word | output | 32 | Target word, one cycle after select |
| msi_valid | output | 1 | Generated message request pulse |
| msi_hart | output | 14 | Destination hart index of generated message |
| msi_eiid | output | 11 | Identity of generated message |

## Verification
The assertions take for granted that reset is held for at least two clock edges, that request fields are known whenever `req_valid` is high, and that `tgt_rd_src` names an existing source whenever its result is used. The bench holds reset for three edges. It changes every input only on the falling clock edge, drives `req_addr`, `req_write` and `req_wdata` to defined values whenever it raises `req_valid`, and reads target words only for sources it has already written. Stimulus covers array words both inside and past the last source. It also covers by-number values of 0, NSRC and NSRC+1, and misaligned offsets for both reads and writes.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_DCFG, RG_SCFG, RG_SETIP, RG_SETIPNUM, RG_INCLRIP, RG_CLRIPNUM,
    RG_SETIE, RG_SETIENUM, RG_CLRIE, RG_CLRIENUM, RG_IPNUM_LE, RG_IPNUM_BE,
    RG_GENMSI, RG_TGT
  } region_e;

  // byte offsets (software-visible layout)
  localparam int unsigned OFS_DCFG     = 32'h0000;
  localparam int unsigned OFS_SCFG     = 32'h0004;
  localparam int unsigned OFS_SETIP    = 32'h1C00;
  localparam int unsigned OFS_SETIPNUM = 32'h1CDC;
  localparam int unsigned OFS_INCLRIP  = 32'h1D00;
  localparam int unsigned OFS_CLRIPNUM = 32'h1DDC;
  localparam int unsigned OFS_SETIE    = 32'h1E00;
  localparam int unsigned OFS_SETIENUM = 32'h1EDC;
  localparam int unsigned OFS_CLRIE    = 32'h1F00;
  localparam int unsigned OFS_CLRIENUM = 32'h1FDC;
  localparam int unsigned OFS_NUM_LE   = 32'h2000;
  localparam int unsigned OFS_NUM_BE   = 32'h2004;
  localparam int unsigned OFS_GENMSI   = 32'h3000;
  localparam int unsigned OFS_TGT      = 32'h3004;

  localparam logic [31:0] DCFG_FIXED  = 32'h8000_0000;
  localparam logic [31:0] DCFG_DMODE  = 32'h0000_0004;
  localparam int          IE_POS      = 8;
  localparam int          DELEG_POS   = 10;
  localparam int          MODE_W      = 3;
  localparam logic [31:0] TGT_KEEP    = 32'hFFFF_F7FF;
  localparam logic [31:0] GENMSI_KEEP = 32'hFFFC_0FFF;
  localparam int          HART_LSB    = 18;
  localparam int          HART_W      = 14;
  localparam int          EIID_W      = 11;

endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
  import irq_rf_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int NSRC   = 40,
  parameter int NWORD  = 2,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              misal,
  output logic [IDX_W-1:0]  idx
);

  logic [31:0] a;
  assign a = 32'(addr);

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    misal  = (a[1:0] != 2'b00);
    if (!misal) begin
      if (a == OFS_DCFG) region = RG_DCFG;
      else if (a >= OFS_SCFG && a < OFS_SCFG + 4*NSRC) begin
        region = RG_SCFG;   idx = IDX_W'((a - OFS_SCFG) >> 2);
      end else if (a >= OFS_SETIP && a < OFS_SETIP + 4*NWORD) begin
        region = RG_SETIP;  idx = IDX_W'((a - OFS_SETIP) >> 2);
      end else if (a == OFS_SETIPNUM) region = RG_SETIPNUM;
      else if (a >= OFS_INCLRIP && a < OFS_INCLRIP + 4*NWORD) begin
        region = RG_INCLRIP; idx = IDX_W'((a - OFS_INCLRIP) >> 2);
      end else if (a == OFS_CLRIPNUM) region = RG_CLRIPNUM;
      else if (a >= OFS_SETIE && a < OFS_SETIE + 4*NWORD) begin
        region = RG_SETIE;  idx = IDX_W'((a - OFS_SETIE) >> 2);
      end else if (a == OFS_SETIENUM) region = RG_SETIENUM;
      else if (a >= OFS_CLRIE && a < OFS_CLRIE + 4*NWORD) begin
        region = RG_CLRIE;  idx = IDX_W'((a - OFS_CLRIE) >> 2);
      end else if (a == OFS_CLRIENUM) region = RG_CLRIENUM;
      else if (a == OFS_NUM_LE)      region = RG_IPNUM_LE;
      else if (a == OFS_NUM_BE)      region = RG_IPNUM_BE;
      else if (a == OFS_GENMSI)      region = RG_GENMSI;
      else if (a >= OFS_TGT && a < OFS_TGT + 4*NSRC) begin
        region = RG_TGT;    idx = IDX_W'((a - OFS_TGT) >> 2);
      end
    end
  end

  // R3 / R9: a per-source slot never decodes past the last source
  always_comb begin
    if (region == RG_SCFG || region == RG_TGT)
      assert_slot_in_range_R3: assert (32'(idx) < NSRC);
  end

endmodule

// File: rtl/irq_rf_tgtmem.sv
module irq_rf_tgtmem #(
  parameter int DEPTH = 40,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [31:0]   rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [31:0]   rdata_b
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/irq_reg_front.sv
module irq_reg_front
  import irq_rf_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int ADDR_W = 14,
  localparam int NBIT  = NSRC + 1,
  localparam int IDX_W = $clog2(NSRC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 resp_valid,
  output logic                 resp_err,
  output logic [31:0]          resp_rdata,
  input  logic [NBIT-1:0]      gw_pend,
  input  logic [NBIT-1:0]      gw_en,
  input  logic [NBIT-1:0]      gw_rect,
  input  logic [NBIT*3-1:0]    gw_cfg,
  output logic [NBIT-1:0]      set_ip,
  output logic [NBIT-1:0]      clr_ip,
  output logic [NBIT-1:0]      set_ie,
  output logic [NBIT-1:0]      clr_ie,
  output logic                 cfg_we,
  output logic [IDX_W-1:0]     cfg_src,
  output logic [2:0]           cfg_val,
  output logic                 dom_ie,
  input  logic [IDX_W-1:0]     tgt_rd_src,
  output logic [31:0]          tgt_rd_word,
  output logic                 msi_valid,
  output logic [13:0]          msi_hart,
  output logic [10:0]          msi_eiid
);

  localparam int NWORD = (NBIT + 31) / 32;
  localparam int PADW  = NWORD * 32;
  localparam logic [NBIT-1:0] NO_SRC0 = ~NBIT'(1);

  region_e          region;
  logic             misal;
  logic [IDX_W-1:0] idx;

  irq_rf_decode #(.ADDR_W(ADDR_W), .NSRC(NSRC), .NWORD(NWORD), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .region(region), .misal(misal), .idx(idx)
  );

  logic acc, wr, rd;
  assign acc = req_valid && !misal;
  assign wr  = acc && req_write;
  assign rd  = acc && !req_write;

  // write-side: array word spread and by-number one-hot
  logic [PADW-1:0]  word_pad;
  logic [NBIT-1:0]  word_bits, num_bits;
  logic [31:0]      num;
  always_comb begin
    word_pad  = PADW'(req_wdata) << (32 * int'(idx));
    word_bits = word_pad[NBIT-1:0] & NO_SRC0;
    num       = (region == RG_IPNUM_BE) ?
                {req_wdata[7:0], req_wdata[15:8], req_wdata[23:16], req_wdata[31:24]} : req_wdata;
    num_bits  = (num != 0 && num <= NSRC) ? (NBIT'(1) << num) : '0;
  end

  logic [NBIT-1:0] set_ip_d, clr_ip_d, set_ie_d, clr_ie_d;
  always_comb begin
    set_ip_d = '0; clr_ip_d = '0; set_ie_d = '0; clr_ie_d = '0;
    if (wr) begin
      case (region)
        RG_SETIP:                               set_ip_d = word_bits;
        RG_SETIPNUM, RG_IPNUM_LE, RG_IPNUM_BE:  set_ip_d = num_bits;
        RG_INCLRIP:                             clr_ip_d = word_bits;
        RG_CLRIPNUM:                            clr_ip_d = num_bits;
        RG_SETIE:                               set_ie_d = word_bits;
        RG_SETIENUM:                            set_ie_d = num_bits;
        RG_CLRIE:                               clr_ie_d = word_bits;
        RG_CLRIENUM:                            clr_ie_d = num_bits;
        default: ;
      endcase
    end
  end

  // read-side mux (target words come from the memory one cycle later)
  logic [PADW-1:0] pend_pad, rect_pad, en_pad;
  logic [31:0]     genmsi_q, rd_d;
  assign pend_pad = PADW'(gw_pend & NO_SRC0);
  assign rect_pad = PADW'(gw_rect & NO_SRC0);
  assign en_pad   = PADW'(gw_en   & NO_SRC0);

  always_comb begin
    rd_d = '0;
    case (region)
      RG_DCFG:    rd_d = DCFG_FIXED | DCFG_DMODE | (32'(dom_ie) << IE_POS);
      RG_SCFG:    rd_d = 32'(gw_cfg[(int'(idx) + 1) * MODE_W +: MODE_W]);
      RG_SETIP:   rd_d = pend_pad[32 * int'(idx) +: 32];
      RG_INCLRIP: rd_d = rect_pad[32 * int'(idx) +: 32];
      RG_SETIE:   rd_d = en_pad[32 * int'(idx) +: 32];
      RG_GENMSI:  rd_d = genmsi_q;
      default:    rd_d = '0;
    endcase
  end

  // target store
  logic [IDX_W-1:0] gw_slot;
  logic [31:0]      tgt_bus_word;
  assign gw_slot = (tgt_rd_src == '0 || tgt_rd_src > IDX_W'(NSRC)) ? '0 : tgt_rd_src - IDX_W'(1);

  irq_rf_tgtmem #(.DEPTH(NSRC), .AW(IDX_W)) u_tgt (
    .clk(clk), .we(wr && region == RG_TGT), .waddr(idx), .wdata(req_wdata & TGT_KEEP),
    .raddr_a(idx), .rdata_a(tgt_bus_word), .raddr_b(gw_slot), .rdata_b(tgt_rd_word)
  );

  logic [31:0] rdat_q;
  logic        sel_tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0; resp_err <= 1'b0; rdat_q <= '0; sel_tgt_q <= 1'b0;
      set_ip <= '0; clr_ip <= '0; set_ie <= '0; clr_ie <= '0;
      cfg_we <= 1'b0; cfg_src <= '0; cfg_val <= '0;
      dom_ie <= 1'b0; genmsi_q <= '0;
      msi_valid <= 1'b0; msi_hart <= '0; msi_eiid <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && misal;
      rdat_q     <= rd ? rd_d : '0;
      sel_tgt_q  <= rd && region == RG_TGT;
      set_ip <= set_ip_d; clr_ip <= clr_ip_d; set_ie <= set_ie_d; clr_ie <= clr_ie_d;
      cfg_we  <= wr && region == RG_SCFG;
      cfg_src <= idx + IDX_W'(1);
      cfg_val <= req_wdata[DELEG_POS] ? 3'd0 : req_wdata[2:0];
      if (wr && region == RG_DCFG) dom_ie <= req_wdata[IE_POS];
      if (wr && region == RG_GENMSI) genmsi_q <= req_wdata & GENMSI_KEEP;
      msi_valid <= wr && region == RG_GENMSI;
      msi_hart  <= req_wdata[HART_LSB +: HART_W];
      msi_eiid  <= req_wdata[EIID_W-1:0];
    end
  end

  assign resp_rdata = sel_tgt_q ? tgt_bus_word : rdat_q;

  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  assert_idle_no_resp_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (resp_rdata == '0 && set_ip == '0 && clr_ip == '0 && set_ie == '0
                  && clr_ie == '0 && !cfg_we && !msi_valid));
  assert_ie_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(dom_ie));
  assert_cfg_src_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> (cfg_src != '0 && cfg_src <= IDX_W'(NSRC)));
  assert_msi_with_resp_R10: assert property (@(posedge clk) disable iff (rst)
    msi_valid |-> (resp_valid && !resp_err));

endmodule

// File: tb/sim_irq_reg_front.sv
module sim_irq_reg_front;

  localparam int NSRC  = 40;
  localparam int NBIT  = NSRC + 1;
  localparam int IDX_W = $clog2(NSRC + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic req_valid = 0, req_write = 0;
  logic [13:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic [NBIT-1:0] gw_pend, gw_en, gw_rect;
  logic [NBIT*3-1:0] gw_cfg;
  logic [NBIT-1:0] set_ip, clr_ip, set_ie, clr_ie;
  logic cfg_we;
  logic [IDX_W-1:0] cfg_src;
  logic [2:0] cfg_val;
  logic dom_ie;
  logic [IDX_W-1:0] tgt_rd_src = '0;
  logic [31:0] tgt_rd_word;
  logic msi_valid;
  logic [13:0] msi_hart;
  logic [10:0] msi_eiid;

  irq_reg_front #(.NSRC(NSRC), .ADDR_W(14)) u0 (
    .clk, .rst, .req_valid, .req_write, .req_addr, .req_wdata,
    .resp_valid, .resp_err, .resp_rdata, .gw_pend, .gw_en, .gw_rect, .gw_cfg,
    .set_ip, .clr_ip, .set_ie, .clr_ie, .cfg_we, .cfg_src, .cfg_val, .dom_ie,
    .tgt_rd_src, .tgt_rd_word, .msi_valid, .msi_hart, .msi_eiid
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access; outputs sampled at the falling edge after the capturing edge
  task automatic acc(input bit w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a[13:0]; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'h0000, 32'h0,          32'h8000_0004, 1'b0, 8'd2},  // R2 reset value
    '{1'b1, 16'h0000, 32'hFFFF_FFFF,  32'h0,         1'b0, 8'd2},
    '{1'b0, 16'h0000, 32'h0,          32'h8000_0104, 1'b0, 8'd2},  // R2 only IE kept
    '{1'b1, 16'h0000, 32'hFFFF_FEFF,  32'h0,         1'b0, 8'd2},
    '{1'b0, 16'h0000, 32'h0,          32'h8000_0004, 1'b0, 8'd2},
    '{1'b0, 16'h0002, 32'h0,          32'h0,         1'b1, 8'd1},  // R1
    '{1'b1, 16'h0003, 32'h0000_0100,  32'h0,         1'b1, 8'd1},  // R1
    '{1'b0, 16'h0000, 32'h0,          32'h8000_0004, 1'b0, 8'd1},  // R1 no IE change
    '{1'b0, 16'h1C00, 32'h0,          32'hF0F0_3C3C, 1'b0, 8'd4},  // R4 pending w0
    '{1'b0, 16'h1C04, 32'h0,          32'h0000_01A5, 1'b0, 8'd4},
    '{1'b0, 16'h1C08, 32'h0,          32'h0,         1'b0, 8'd12}, // R12 past last word
    '{1'b0, 16'h1D00, 32'h0,          32'h8765_4320, 1'b0, 8'd4},  // R4 rectified
    '{1'b0, 16'h1D04, 32'h0,          32'h0000_0012, 1'b0, 8'd4},
    '{1'b0, 16'h1E00, 32'h0,          32'hFFFF_0000, 1'b0, 8'd4},  // R4 enables
    '{1'b0, 16'h1F00, 32'h0,          32'h0,         1'b0, 8'd5},  // R5
    '{1'b0, 16'h1CDC, 32'h0,          32'h0,         1'b0, 8'd5},
    '{1'b0, 16'h2004, 32'h0,          32'h0,         1'b0, 8'd5},
    '{1'b0, 16'h0004, 32'h0,          32'h0000_0004, 1'b0, 8'd3},  // R3 source 1
    '{1'b0, 16'h00A0, 32'h0,          32'h0000_0007, 1'b0, 8'd3},  // R3 source 40
    '{1'b0, 16'h00A4, 32'h0,          32'h0,         1'b0, 8'd12}, // R12
    '{1'b1, 16'h3004, 32'hFFFF_FFFF,  32'h0,         1'b0, 8'd9},
    '{1'b0, 16'h3004, 32'h0,          32'hFFFF_F7FF, 1'b0, 8'd9},  // R9 mask
    '{1'b1, 16'h3000, 32'hFFFF_FFFF,  32'h0,         1'b0, 8'd10},
    '{1'b0, 16'h3000, 32'h0,          32'hFFFC_0FFF, 1'b0, 8'd10}, // R10 mask
    '{1'b1, 16'h2FFC, 32'hFFFF_FFFF,  32'h0,         1'b0, 8'd12}  // R12
  };

  function automatic logic [NBIT-1:0] bit_at(input int n);
    return NBIT'(1) << n;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    gw_pend = {1'b1, 40'hA5_F0F0_3C3D};
    gw_rect = {1'b0, 40'h12_8765_4321};
    gw_en   = {1'b1, 40'h00_FFFF_0001};
    gw_cfg  = '0;
    gw_cfg[1*3 +: 3]  = 3'd4;
    gw_cfg[40*3 +: 3] = 3'd7;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R11, R2)
    chk(!resp_valid && set_ip == '0 && !cfg_we && !msi_valid, "R11 reset idle",
        {resp_valid, cfg_we, msi_valid}, 0);
    chk(dom_ie == 0, "R2 reset ie", dom_ie, 0);

    for (int i = 0; i < NV; i++) begin
      acc(TBL[i].wr, TBL[i].addr, TBL[i].wd);
      chk(resp_valid && resp_err == TBL[i].err && resp_rdata == TBL[i].exp,
          $sformatf("R%0d table row %0d", TBL[i].req, i),
          {resp_err, resp_rdata}, {TBL[i].err, TBL[i].exp});
    end
    @(negedge clk);
    chk(!resp_valid, "R11 no response when idle", resp_valid, 0);

    // array write strobes R6
    acc(1, 16'h1C00, 32'h0000_0003);
    chk(set_ip == bit_at(1) && clr_ip == '0, "R6 set-pending word0, src0 dropped", set_ip, bit_at(1));
    acc(1, 16'h1F04, 32'h0000_0101);
    chk(clr_ie == (bit_at(32) | bit_at(40)), "R6 clear-enable word1", clr_ie, bit_at(32) | bit_at(40));
    acc(1, 16'h1D04, 32'hFFFF_FFFF);
    chk(clr_ip == {9'h1FF, 32'h0}, "R6 clear-pending word1 truncated", clr_ip, {9'h1FF, 32'h0});
    acc(1, 16'h1E00, 32'h0);
    chk(set_ie == '0, "R6 zero bits no effect", set_ie, 0);
    acc(1, 16'h1C01, 32'hFFFF_FFFF);
    chk(resp_err && set_ip == '0, "R1 misaligned write no strobe", set_ip, 0);

    // by-number R7
    acc(1, 16'h1CDC, 32'd5);
    chk(set_ip == bit_at(5), "R7 setipnum 5", set_ip, bit_at(5));
    acc(1, 16'h1CDC, 32'd0);
    chk(set_ip == '0, "R7 number 0 ignored", set_ip, 0);
    acc(1, 16'h1CDC, 32'd41);
    chk(set_ip == '0, "R7 number past last ignored", set_ip, 0);
    acc(1, 16'h1DDC, 32'd40);
    chk(clr_ip == bit_at(40), "R7 clripnum 40", clr_ip, bit_at(40));
    acc(1, 16'h1EDC, 32'd1);
    chk(set_ie == bit_at(1), "R7 setienum 1", set_ie, bit_at(1));
    acc(1, 16'h1FDC, 32'd7);
    chk(clr_ie == bit_at(7), "R7 clrienum 7", clr_ie, bit_at(7));
    acc(1, 16'h2000, 32'd3);
    chk(set_ip == bit_at(3), "R7 little-endian alias", set_ip, bit_at(3));

    // byte swap R8
    acc(1, 16'h2004, 32'h0900_0000);
    chk(set_ip == bit_at(9), "R8 swapped number", set_ip, bit_at(9));
    acc(1, 16'h2004, 32'h0000_0009);
    chk(set_ip == '0, "R8 unswapped value out of range", set_ip, 0);

    // configuration write R3
    acc(1, 16'h0008, 32'h0000_0006);
    chk(cfg_we && cfg_src == 2 && cfg_val == 6, "R3 cfg write src2",
        {cfg_we, 2'b0, cfg_src, cfg_val}, {1'b1, 2'b0, 6'd2, 3'd6});
    acc(1, 16'h0008, 32'h0000_0406);
    chk(cfg_we && cfg_val == 0, "R3 delegate bit forces 0", cfg_val, 0);

    // target port R9
    acc(1, 16'h3008, 32'h1234_5ABC);
    @(negedge clk); tgt_rd_src = 6'd2;
    @(negedge clk);
    chk(tgt_rd_word == 32'h1234_52BC, "R9 gateway target read", tgt_rd_word, 32'h1234_52BC);
    acc(0, 16'h3008, 32'h0);
    chk(resp_rdata == 32'h1234_52BC, "R9 bus target read", resp_rdata, 32'h1234_52BC);

    // message R10
    acc(1, 16'h3000, 32'h0004_0123);
    chk(msi_valid && msi_hart == 14'd1 && msi_eiid == 11'h123, "R10 message pulse",
        {msi_valid, msi_hart, msi_eiid}, {1'b1, 14'd1, 11'h123});
    @(negedge clk);
    chk(!msi_valid, "R10 pulse one cycle", msi_valid, 0);

    // mid-run reset R2
    acc(1, 16'h0000, 32'h0000_0100);
    chk(dom_ie, "R2 ie set", dom_ie, 1);
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    acc(0, 16'h0000, 32'h0);
    chk(resp_rdata == 32'h8000_0004, "R2 ie cleared by reset", resp_rdata, 32'h8000_0004);

    finish_run();
  end

endmodule